// File: doc/BRIEF.md
# Frame Buffer Fill and Copy Blitter

This block moves short horizontal runs of 8-bit pixels inside a byte-addressed frame buffer. The host talks to it through a plain word write port. A write with address bit 2 clear stores a colour word. A write with address bit 2 set starts a command. The destination pixel address comes from the write address. The data word carries a source pixel address and a run length of 1 to 32 pixels. If the source field is all ones, the run is filled with the low byte of the stored colour. Any other source value copies the run from source to destination.

The engine reaches the frame buffer through one single-port byte memory master using valid/ready. A request holds valid, address, write flag and write data steady until ready is seen high on a clock edge. At most one read is outstanding. Its response comes back on a separate response-valid strobe that has no back-pressure, at least one cycle after the read was accepted. While the engine is busy, the host must hold new commands. A command issued anyway is dropped and sets a sticky error flag. When a run finishes, a one-cycle done pulse reports the destination start address and the run length, so that refresh logic can mark the region as changed.

Top module: `blt_fill_copy`

## Requirements
- R1: A write with address bit 2 clear stores data bits 7:0 as the pending colour and starts no command: busy stays low and no memory request appears.
- R2: A write with address bit 2 set, while idle, starts a command with destination pixel address equal to address bits 22:3; all other address bits except bit 2 are ignored; busy is high from the next cycle.
- R3: The run length is data bits 28:24 plus one (1 to 32 pixels); data bits 31:29 are ignored.
- R4: When data bits 23:0 equal 0xFFFFFF, every pixel from the destination upward for the run length is written with the colour byte, and no memory read is issued.
- R5: For any other source value, pixel i of the run (i from 0 upward) is read from source+i and then written to destination+i before pixel i+1 is read, so an overlapping run behaves as a forward byte copy.
- R6: The register read data output is always zero.
- R7: A command write while busy is ignored (no memory traffic, no done pulse) and sets the error flag, which stays high until reset.
- R8: After the last write of a run is accepted, done_valid is high for exactly one cycle with done_addr equal to the destination and done_len equal to the run length; busy is low in that cycle.
- R9: A memory request held while ready is low keeps valid, address, write flag and write data unchanged in the next cycle.
- R10: The colour used by a fill is the one stored when the command started; a colour write during a run only affects later fills.
- R11: After reset, busy, error, done_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 32 | Register write address (bit 2 selects command, bits 22:3 destination) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, always zero |
| busy | output | 1 | A run is in progress |
| err | output | 1 | Sticky: a command arrived while busy |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 24 | Pixel byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 8 | Read response byte |
| done_valid | output | 1 | One-cycle completion pulse |
| done_addr | output | 20 | Destination start of the finished run |
| done_len | output | 6 | Length of the finished run |

## Verification
The hardest cases to reach are those that depend on host writes arriving during a run. One is a command dropped while busy. The other is a colour rewrite that must not affect the fill already in progress. The stimulus issues these writes on the very next cycle after a command, while the memory model stalls ready on every third cycle so the run is still active. An overlapping forward copy, checked against a byte-by-byte reference, exposes any reordering of the read and write steps.

// File: rtl/blt_pkg.sv
package blt_pkg;
  parameter int PIX_W   = 8;
  parameter int SRC_W   = 24;
  parameter int DST_W   = 20;
  parameter int LEN_W   = 5;
  parameter int REG_W   = 32;
  parameter int DST_LSB = 3;
  parameter int CMD_BIT = 2;

  localparam int MEM_AW = SRC_W;
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [SRC_W-1:0] FILL_CODE = {SRC_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RWAIT, ST_WR} blt_state_e;

  typedef struct packed {
    logic [DST_W-1:0] dst;
    logic [SRC_W-1:0] src;
    logic [LEN_W-1:0] len_m1;
    logic             fill;
    logic [PIX_W-1:0] colour;
  } blt_cmd_t;
endpackage

// File: rtl/blt_cmd_dec.sv
module blt_cmd_dec
  import blt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] data,
  input  logic             busy,
  output logic             start,
  output blt_cmd_t         cmd,
  output logic             err
);
  logic [PIX_W-1:0] colour_q;
  logic             err_q;
  logic             is_cmd;
  logic [SRC_W-1:0] src_f;
  logic             unused_bits;

  assign is_cmd = addr[CMD_BIT];
  assign src_f  = data[SRC_W-1:0];
  assign start  = wr_en && is_cmd && !busy;

  assign cmd.dst    = addr[DST_LSB +: DST_W];
  assign cmd.src    = src_f;
  assign cmd.len_m1 = data[SRC_W +: LEN_W];
  assign cmd.fill   = (src_f == FILL_CODE);
  assign cmd.colour = colour_q;
  assign err        = err_q;

  assign unused_bits = ^{addr[CMD_BIT-1:0], addr[REG_W-1:DST_LSB+DST_W],
                         data[REG_W-1:SRC_W+LEN_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colour_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_en && !is_cmd) colour_q <= data[PIX_W-1:0];
      if (wr_en && is_cmd && busy) err_q <= 1'b1;
    end
  end

  // R7: error flag never clears outside reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7: a command during a run leaves the flag set
  a_r7_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_cmd && busy) |=> err);
endmodule

// File: rtl/blt_engine.sv
module blt_engine
  import blt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  blt_cmd_t          cmd,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [PIX_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [DST_W-1:0]  done_addr,
  output logic [CNT_W-1:0]  done_len
);
  blt_state_e       state;
  logic [LEN_W-1:0] idx;
  logic [DST_W-1:0] dst_q;
  logic [SRC_W-1:0] src_q;
  logic [LEN_W-1:0] len_m1_q;
  logic             fill_q;
  logic [PIX_W-1:0] colour_q;
  logic [PIX_W-1:0] rd_byte;
  logic             done_q;
  logic             last_px;

  assign busy          = (state != ST_IDLE);
  assign last_px       = (idx == len_m1_q);
  assign mem_req_valid = (state == ST_RD) || (state == ST_WR);
  assign mem_we        = (state == ST_WR);
  assign mem_addr      = (state == ST_WR) ? (MEM_AW'(dst_q) + MEM_AW'(idx))
                                          : (src_q + MEM_AW'(idx));
  assign mem_wdata     = fill_q ? colour_q : rd_byte;
  assign done_valid    = done_q;
  assign done_addr     = dst_q;
  assign done_len      = CNT_W'(len_m1_q) + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      len_m1_q <= '0;
      fill_q   <= 1'b0;
      colour_q <= '0;
      rd_byte  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          dst_q    <= cmd.dst;
          src_q    <= cmd.src;
          len_m1_q <= cmd.len_m1;
          fill_q   <= cmd.fill;
          colour_q <= cmd.colour;
          idx      <= '0;
          state    <= cmd.fill ? ST_WR : ST_RD;
        end
        ST_RD: if (mem_req_ready) state <= ST_RWAIT;
        ST_RWAIT: if (mem_rsp_valid) begin
          rd_byte <= mem_rsp_data;
          state   <= ST_WR;
        end
        ST_WR: if (mem_req_ready) begin
          if (last_px) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= fill_q ? ST_WR : ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled request keeps all its fields
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R4: a fill run never reads
  a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && fill_q) |-> mem_we);
  // R8: done is a single-cycle pulse seen with busy low
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy);
  // R3: pixel index stays within the run
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= len_m1_q));
  // R2: an accepted command makes the engine busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/blt_fill_copy.sv
module blt_fill_copy
  import blt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              busy,
  output logic              err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [PIX_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [DST_W-1:0]  done_addr,
  output logic [CNT_W-1:0]  done_len
);
  logic     start;
  blt_cmd_t cmd;

  assign reg_rdata = '0;

  blt_cmd_dec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .data  (reg_wdata),
    .busy  (busy),
    .start (start),
    .cmd   (cmd),
    .err   (err)
  );

  blt_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cmd           (cmd),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done_valid    (done_valid),
    .done_addr     (done_addr),
    .done_len      (done_len)
  );

  // R1: a colour write while idle starts nothing
  a_r1_colour_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr_en && !reg_addr[CMD_BIT]) |=> !busy);
endmodule

// File: tb/sim_blt_fill_copy.sv
`timescale 1ns/1ps
module sim_blt_fill_copy;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, err;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        done_valid;
  logic [19:0] done_addr;
  logic [5:0]  done_len;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R11";

  logic [7:0]  mem [0:4095];
  logic [7:0]  refm [0:4095];
  logic [32:0] exp_q [$];
  logic [25:0] done_q [$];
  logic        pend = 1'b0;
  logic [7:0]  pend_data = '0;

  always #2.5 clk = ~clk;

  blt_fill_copy u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    logic [32:0] e;
    logic [25:0] d;
    cyc++;
    if (pend) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    mem_req_ready = (cyc % 3) != 0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s: unexpected request actual we=%0d addr 0x%0h expected none",
                 cur_req, mem_we, mem_addr);
      end else begin
        e = exp_q.pop_front();
        chk(cur_req, {7'b0, mem_we, mem_addr}, {7'b0, e[32], e[31:8]});
        if (mem_we) chk(cur_req, {24'b0, mem_wdata}, {24'b0, e[7:0]});
      end
      if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
      else begin pend = 1'b1; pend_data = mem[mem_addr[11:0]]; end
    end
    if (rst_n && done_valid) begin
      if (done_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected done actual addr 0x%0h expected none", done_addr);
      end else begin
        d = done_q.pop_front();
        chk("R8", {12'b0, done_addr}, {12'b0, d[25:6]});
        chk("R8", {26'b0, done_len}, {26'b0, d[5:0]});
        chk("R8", {31'b0, busy}, 32'd0);
      end
    end
  end

  task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cmd_addr(input int dst);
    return (32'(dst) << 3) | 32'h4;
  endfunction

  task automatic wait_idle(input string req);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(req, exp_q.size(), 0);
    chk(req, done_q.size(), 0);
  endtask

  task automatic push_fill(input int dst, input int len, input logic [7:0] col);
    for (int i = 0; i < len; i++) begin
      refm[dst+i] = col;
      exp_q.push_back({1'b1, 24'(dst+i), col});
    end
    done_q.push_back({20'(dst), 6'(len)});
  endtask

  task automatic push_copy(input int dst, input int src, input int len);
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({1'b0, 24'(src+i), 8'h00});
      refm[dst+i] = refm[src+i];
      exp_q.push_back({1'b1, 24'(dst+i), refm[dst+i]});
    end
    done_q.push_back({20'(dst), 6'(len)});
  endtask

  task automatic do_copy(input string req, input int dst, input int src, input int len);
    cur_req = req;
    push_copy(dst, src, len);
    reg_write(cmd_addr(dst), {3'b000, 5'(len-1), 24'(src)});
    wait_idle(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL %s: watchdog expired actual hung expected finished", cur_req);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 37 + 11);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {31'b0, busy}, 0);
    chk("R11", {31'b0, err}, 0);
    chk("R11", {31'b0, done_valid}, 0);
    chk("R11", {31'b0, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", reg_rdata, 0);

    // R1 colour write only
    cur_req = "R1";
    reg_write(32'h0000_0000, 32'hFFFF_FFA5);
    repeat (5) @(negedge clk);
    chk("R1", {31'b0, busy}, 0);

    // R2/R3/R4 single-pixel fill with junk in ignored address and data bits
    cur_req = "R4";
    push_fill(16, 1, 8'hA5);
    reg_write(cmd_addr(16) | 32'h4080_0003, {3'b111, 5'd0, 24'hFFFFFF});
    chk("R2", {31'b0, busy}, 1);
    chk("R6", reg_rdata, 0);
    wait_idle("R2");

    // R3 maximum length fill
    cur_req = "R3";
    reg_write(32'h0000_0008, 32'h0000_003C);
    push_fill(256, 32, 8'h3C);
    reg_write(cmd_addr(256), {3'b000, 5'd31, 24'hFFFFFF});
    wait_idle("R3");

    // R5 plain copies
    do_copy("R5", 1024, 40, 8);
    do_copy("R5", 1536, 300, 32);
    // R5 overlapping forward copy
    do_copy("R5", 514, 512, 10);
    // copy back from a filled region
    do_copy("R5", 2048, 256, 4);

    // R7 collision
    cur_req = "R7";
    push_fill(3000, 6, 8'h3C);
    reg_write(cmd_addr(3000), {3'b000, 5'd5, 24'hFFFFFF});
    reg_write(cmd_addr(3100), {3'b000, 5'd3, 24'd10});
    chk("R7", {31'b0, err}, 1);
    wait_idle("R7");
    chk("R7", {31'b0, err}, 1);

    // R10 colour rewrite during a fill
    cur_req = "R10";
    reg_write(32'h0, 32'h0000_005A);
    push_fill(3200, 12, 8'h5A);
    reg_write(cmd_addr(3200), {3'b000, 5'd11, 24'hFFFFFF});
    chk("R10", {31'b0, busy}, 1);
    reg_write(32'h0, 32'h0000_00C3);
    wait_idle("R10");
    push_fill(3300, 3, 8'hC3);
    reg_write(cmd_addr(3300), {3'b000, 5'd2, 24'hFFFFFF});
    wait_idle("R10");

    // R11 reset clears the error flag
    cur_req = "R11";
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", {31'b0, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // final memory comparison against reference (R5)
    for (int i = 0; i < 4096; i++) begin
      if (mem[i] !== refm[i]) begin
        checks++; errors++;
        $display("FAIL R5: mem[%0d] actual 0x%0h expected 0x%0h", i, mem[i], refm[i]);
      end
    end
    checks++;
    chk("R6", reg_rdata, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule